// File: doc/BRIEF.md
# Transition-Count Serial Clock Generator

This block produces a serial clock burst by flipping an output a programmed number of times. The number of system clocks between flips comes from an interval input, and a burst begins when a non-zero transition count is written. The interval is a half-period rather than a full period, and the count is a number of edges rather than cycles. So a count of 16 gives eight complete clock periods, which is enough to move one byte.

When the final transition has happened, a completion flag goes high. The flag stays high until an acknowledge pulse clears it, so software can poll it at any pace. While the pin enable input is low, the block is held in a synchronous reset. A polarity input chooses whether the clock idles low or high. Chip-select handling and data shifting belong to neighbouring logic.

The controller is a three-state machine. The states are:

- `ST_IDLE`: waiting for a count write.
- `ST_RUN`: the burst is in progress.
- `ST_DONE`: the completion flag is pending.

The transitions are:

- start (`ST_IDLE` to `ST_RUN`), taken on a non-zero count write.
- finish (`ST_RUN` to `ST_DONE`), taken on the last transition.
- acknowledge (`ST_DONE` to `ST_IDLE`).
- disable (any state to `ST_IDLE`, taken while the pin enable is low).

Top module: `tcount_sclk_gen`

## Requirements
- R1: The block starts a burst when `count_wr_i` is high in `ST_IDLE` and `count_i` is non-zero. The interval is captured at that accepting edge. The first transition of `sclk_o` happens N clock edges later, where N is `interval_i`, or 1 if `interval_i` is 0.
- R2: A write of count 0 does not start a burst. The block stays idle, `sclk_o` does not move and `done_o` stays low.
- R3: A burst makes exactly C transitions of `sclk_o`, where C is the written count. Consecutive transitions are N clocks apart, because the interval counter reloads after every transition.
- R4: `done_o` rises on the same edge as the last transition. It then stays high for as long as `done_ack_i` is low.
- R5: An acknowledge while `done_o` is high has effect on the next edge. It clears `done_o` and returns `sclk_o` to its idle level. An acknowledge at any other time has no effect.
- R6: Count writes made while a burst is running, or while `done_o` is pending, are ignored. They do not change the transition count, the timing or the flag.
- R7: When `pin_en_i` is low at an edge, the block goes idle after that edge. The burst is cancelled, `done_o` is cleared and `sclk_o` returns to its idle level. The asynchronous `rst_ni` gives the same state.
- R8: `sclk_o` equals the internal clock level XOR `invert_i`. The idle level is therefore low when `invert_i` is 0 and high when `invert_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_en_i | input | 1 | Enable; low holds the block in synchronous reset |
| invert_i | input | 1 | Output polarity; 1 gives clock-high idle |
| interval_i | input | IVL_W | System clocks between transitions (0 is treated as 1) |
| count_i | input | CNT_W | Number of output transitions |
| count_wr_i | input | 1 | Count write strobe; starts a burst when idle |
| done_ack_i | input | 1 | Acknowledge that clears the completion flag |
| sclk_o | output | 1 | Generated serial clock |
| done_o | output | 1 | Sticky completion flag |

## Verification
The assertions check the following on every cycle:

- The flag holds while it is pending.
- The flag clears, and the idle level returns, after an acknowledge.
- Disable forces the block idle.
- A zero count keeps the machine in `ST_IDLE`.
- `sclk_o` moves only when the previous state was running or done.
- The flag can rise only out of `ST_RUN`.

Some behaviour can only be shown by the bench's scenarios. These are the exact number of transitions, the equal spacing set by each interval, the capture of the interval at start, and that count writes and acknowledges made mid-burst leave the waveform unchanged.

// File: rtl/tcount_sclk_pkg.sv
`timescale 1ns/1ps
package tcount_sclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sclk_state_e;
endpackage

// File: rtl/tcount_interval_timer.sv
`timescale 1ns/1ps
// Half-period timer: captures the interval at load and ticks once every
// max(interval,1) cycles while run is high, reloading after every tick.
module tcount_interval_timer #(
    parameter int IVL_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [IVL_W-1:0] period_i,
    output logic             tick_o
);
    localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

    logic [IVL_W-1:0] per_q;
    logic [IVL_W-1:0] cnt_q;
    logic [IVL_W-1:0] per_eff;

    assign per_eff = (period_i == '0) ? ONE : period_i;
    assign tick_o  = run_i && (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            per_q <= ONE;
            cnt_q <= '0;
        end else if (clr_i) begin
            per_q <= ONE;
            cnt_q <= '0;
        end else if (load_i) begin
            per_q <= per_eff;
            cnt_q <= per_eff - ONE;
        end else if (run_i) begin
            cnt_q <= tick_o ? (per_q - ONE) : (cnt_q - ONE);
        end
    end
endmodule

// File: rtl/tcount_edge_counter.sv
`timescale 1ns/1ps
// Counts remaining output transitions; flags the final one.
module tcount_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    assign last_o = dec_i && (rem_q == ONE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
        end else if (clr_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= count_i;
        end else if (dec_i && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end
endmodule

// File: rtl/tcount_sclk_gen.sv
`timescale 1ns/1ps
module tcount_sclk_gen
    import tcount_sclk_pkg::*;
#(
    parameter int IVL_W = 20,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_en_i,
    input  logic             invert_i,
    input  logic [IVL_W-1:0] interval_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             count_wr_i,
    input  logic             done_ack_i,
    output logic             sclk_o,
    output logic             done_o
);
    sclk_state_e state_q, state_d;
    logic        start;
    logic        running;
    logic        tick;
    logic        last;
    logic        lvl_q;

    assign running = (state_q == ST_RUN);
    assign start   = (state_q == ST_IDLE) && count_wr_i && (count_i != '0);

    tcount_interval_timer #(.IVL_W(IVL_W)) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (!pin_en_i),
        .load_i   (start),
        .run_i    (running),
        .period_i (interval_i),
        .tick_o   (tick)
    );

    tcount_edge_counter #(.CNT_W(CNT_W)) edges_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (!pin_en_i),
        .load_i  (start),
        .count_i (count_i),
        .dec_i   (tick),
        .last_o  (last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)      state_d = ST_RUN;
            ST_RUN:  if (last)       state_d = ST_DONE;
            ST_DONE: if (done_ack_i) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        state_q <= ST_IDLE;
        else if (!pin_en_i) state_q <= ST_IDLE;
        else                state_q <= state_d;
    end

    // Output register: internal clock level
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                lvl_q <= 1'b0;
        else if (!pin_en_i)                         lvl_q <= 1'b0;
        else if (tick)                              lvl_q <= ~lvl_q;
        else if (state_q == ST_DONE && done_ack_i)  lvl_q <= 1'b0;
    end

    assign sclk_o = lvl_q ^ invert_i;
    assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/tcount_sclk_chk.sv
`timescale 1ns/1ps
module tcount_sclk_chk
    import tcount_sclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pin_en_i,
    input logic             invert_i,
    input logic [CNT_W-1:0] count_i,
    input logic             count_wr_i,
    input logic             done_ack_i,
    input logic             sclk_o,
    input logic             done_o,
    input sclk_state_e      state_q
);
    a_r4_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_en_i && done_o && !done_ack_i) |=> done_o);

    a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_en_i && done_o && done_ack_i) |=> (!done_o && (sclk_o == invert_i)));

    a_r7_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pin_en_i) |=> (!done_o && (sclk_o == invert_i) && state_q == ST_IDLE));

    a_r2_zero_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_en_i && state_q == ST_IDLE && count_wr_i && count_i == '0) |=> (state_q == ST_IDLE));

    a_r3_moves_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(pin_en_i) && $stable(invert_i) && !$stable(sclk_o))
            |-> ($past(state_q) == ST_RUN || $past(state_q) == ST_DONE));

    a_r4_done_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> ($past(state_q) == ST_RUN));
endmodule

bind tcount_sclk_gen tcount_sclk_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_en_i   (pin_en_i),
    .invert_i   (invert_i),
    .count_i    (count_i),
    .count_wr_i (count_wr_i),
    .done_ack_i (done_ack_i),
    .sclk_o     (sclk_o),
    .done_o     (done_o),
    .state_q    (state_q)
);

// File: tb/tcount_sclk_gen_tb_top.sv
`timescale 1ns/1ps
module tcount_sclk_gen_tb_top;
    localparam int IVL_W = 20;
    localparam int CNT_W = 8;
    localparam int NV    = 6;
    localparam int VEC_IVL [NV] = '{1, 3, 2, 4, 1, 0};
    localparam int VEC_CNT [NV] = '{16, 16, 5, 1, 2, 3};
    localparam bit VEC_INV [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_en = 1'b1;
    logic             invert = 1'b0;
    logic [IVL_W-1:0] interval = '0;
    logic [CNT_W-1:0] count = '0;
    logic             count_wr = 1'b0;
    logic             ack = 1'b0;
    logic             sclk;
    logic             done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    tcount_sclk_gen #(.IVL_W(IVL_W), .CNT_W(CNT_W)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pin_en_i   (pin_en),
        .invert_i   (invert),
        .interval_i (interval),
        .count_i    (count),
        .count_wr_i (count_wr),
        .done_ack_i (ack),
        .sclk_o     (sclk),
        .done_o     (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts a burst, watches every cycle, optionally injects a count write
    // (wr_k) or an acknowledge (ack_k) mid-burst, and optionally acknowledges.
    task automatic run_burst(input int ivl, input int cnt, input bit inv,
                             input int wr_k, input int ack_k, input bit do_ack,
                             output int bad);
        int n;
        int span;
        int bad_s;
        int bad_d;
        n = (ivl < 1) ? 1 : ivl;
        span = n * cnt;
        bad_s = 0;
        bad_d = 0;
        @(negedge clk);
        invert = inv;
        interval = IVL_W'(ivl);
        count = CNT_W'(cnt);
        count_wr = 1'b1;
        @(negedge clk);
        count_wr = 1'b0;
        if (sclk !== inv) bad_s++;
        for (int k = 1; k <= span + 3; k++) begin
            int tg;
            logic exp_s;
            if (k == wr_k) begin count = CNT_W'(7); count_wr = 1'b1; end
            if (k == ack_k) ack = 1'b1;
            @(negedge clk);
            count_wr = 1'b0;
            ack = 1'b0;
            tg = k / n;
            if (tg > cnt) tg = cnt;
            exp_s = inv ^ tg[0];
            if (sclk !== exp_s) bad_s++;
            if (done !== (k >= span)) bad_d++;
        end
        check(bad_s == 0, "R1 R3 transition count and spacing", bad_s, 0);
        check(bad_d == 0, "R4 done timing and hold", bad_d, 0);
        bad = bad_s + bad_d;
        if (do_ack) begin
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            check(done == 1'b0, "R5 ack clears done", int'(done), 0);
            check(sclk == inv, "R5 idle level after ack", int'(sclk), int'(inv));
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        check(sclk == 1'b0, "R7 reset sclk idle", int'(sclk), 0);
        check(done == 1'b0, "R7 reset done low", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of vectors
        for (int v = 0; v < NV; v++)
            run_burst(VEC_IVL[v], VEC_CNT[v], VEC_INV[v], 0, 0, 1'b1, bad);

        // R2: zero count
        begin
            int moves;
            moves = 0;
            invert = 1'b0;
            count = '0;
            interval = IVL_W'(1);
            count_wr = 1'b1;
            @(negedge clk);
            count_wr = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (sclk !== 1'b0 || done !== 1'b0) moves++;
            end
            check(moves == 0, "R2 zero count no burst", moves, 0);
        end

        // R6: write during run ignored
        run_burst(2, 8, 1'b0, 5, 0, 1'b1, bad);
        check(bad == 0, "R6 write mid-burst ignored", bad, 0);

        // R5: ack during run ignored
        run_burst(3, 4, 1'b0, 0, 6, 1'b1, bad);
        check(bad == 0, "R5 ack mid-burst ignored", bad, 0);

        // R6: write while done pending ignored
        run_burst(1, 2, 1'b0, 0, 0, 1'b0, bad);
        begin
            int moves;
            moves = 0;
            count = CNT_W'(4);
            count_wr = 1'b1;
            @(negedge clk);
            count_wr = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (sclk !== 1'b0 || done !== 1'b1) moves++;
            end
            check(moves == 0, "R6 write while done ignored", moves, 0);
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            check(done == 1'b0, "R5 ack after pending write", int'(done), 0);
        end

        // R7: disable mid-burst
        interval = IVL_W'(3);
        count = CNT_W'(10);
        count_wr = 1'b1;
        @(negedge clk);
        count_wr = 1'b0;
        repeat (4) @(negedge clk);
        check(sclk == 1'b1, "R7 burst running before disable", int'(sclk), 1);
        pin_en = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R7 disable returns idle level", int'(sclk), 0);
        pin_en = 1'b1;
        begin
            int moves;
            moves = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (sclk !== 1'b0 || done !== 1'b0) moves++;
            end
            check(moves == 0, "R7 burst cancelled by disable", moves, 0);
        end

        // R7: disable clears pending done
        run_burst(1, 1, 1'b0, 0, 0, 1'b0, bad);
        pin_en = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7 disable clears done", int'(done), 0);
        check(sclk == 1'b0, "R7 disable clears level", int'(sclk), 0);
        pin_en = 1'b1;

        // R8: idle polarity
        invert = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R8 inverted idle high", int'(sclk), 1);
        invert = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R8 normal idle low", int'(sclk), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule